// File: doc/BRIEF.md
# Audio Sample FIFO with Watermark Control

A word-wide first-in first-out buffer placed between a DMA or bus master and a serial audio shifter. One side pushes 32-bit sample words, the other pops them. A two-bit operation register gates the buffer. One bit empties it and the other lets traffic flow. A programmable fill watermark drives a live service request and a sticky interrupt flag. The direction parameter chooses which side of the watermark counts as "needs service". A receive buffer asks to be drained once the level reaches the watermark. A transmit buffer asks to be refilled once the level falls to the watermark.

Software starts the buffer in three steps: write the reset bit, clear the register, then write the start bit. Writing zero stops the buffer and keeps its contents. Status is reported as the fill level in entries, plus full and empty. Events collect in a 16-bit sticky interrupt vector that is cleared by writing ones.

Top module: `audio_wm_fifo`

## Requirements
- R1: The operation register takes its value on a cycle with `op_we`. Bit 0 is flush and bit 1 is run. While the registered bit 0 is 1, every clock edge empties the buffer, so `level` reads 0 and `empty` reads 1 one cycle later. Flush wins over run: pushes made while both bits are set are not stored.
- R2: While the registered operation value is 0 (stopped), pushes and pops are ignored. The level, the contents and `pop_data` keep their values.
- R3: The buffer holds `DEPTH` (32) words of 32 bits in arrival order. `level` counts the stored words, `full` is 1 exactly when `level` equals `DEPTH`, and `empty` is 1 exactly when `level` is 0.
- R4: A push to a full buffer without a pop on the same cycle is dropped. It sets interrupt bit 2 (overflow).
- R5: A pop from an empty buffer while running loads 0 into `pop_data` and sets interrupt bit 3 (underflow).
- R6: A successful pop places the oldest word on `pop_data` on the cycle after the pop. `pop_data` holds that value until the next pop.
- R7: The watermark resets to `DEPTH/2` (16). A cycle with `thr_we` loads `thr_wdata` into it.
- R8: With `IS_RX=1` the watermark condition is level >= watermark, and it sets interrupt bit 8. With `IS_RX=0` the condition is level <= watermark, and it sets interrupt bit 9. `req` is 1 while running and the condition holds.
- R9: Each cycle the buffer runs while full, interrupt bit 6 is set. Each cycle it runs while empty, interrupt bit 7 is set.
- R10: Interrupt bits are sticky. A 1 in `irq_clr_data` on a cycle with `irq_clr_we` clears that bit, but an event on the same cycle keeps it set.
- R11: A push and a pop on the same cycle while full both succeed, and the level stays at `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_we | input | 1 | Load the operation register |
| op_wdata | input | 2 | Operation value: bit 0 flush, bit 1 run |
| thr_we | input | 1 | Load the watermark |
| thr_wdata | input | 7 | New watermark in words |
| push | input | 1 | Push a word |
| push_data | input | 32 | Word to push |
| pop | input | 1 | Pop a word |
| pop_data | output | 32 | Last popped word, or 0 after underflow |
| level | output | 7 | Stored word count |
| full | output | 1 | Buffer full |
| empty | output | 1 | Buffer empty |
| req | output | 1 | Live watermark service request |
| irq_clr_we | input | 1 | Apply the write-one-to-clear mask |
| irq_clr_data | input | 16 | Bits to clear |
| irq_status | output | 16 | Sticky interrupt flags |

## Verification
The hardest states to reach are a simultaneous clear and event on one flag bit, and a push plus pop on the same cycle while full. The bench reaches the first by stopping the buffer so that no flag re-arms, clearing it, then restarting into an underflow with the clear applied on that very cycle. It reaches the second by filling to overflow before issuing the paired push and pop. One receive instance and one transmit instance share the stimulus. A behavioural queue model then follows a long random phase in which run, stop, flush, watermark changes and clears are interleaved, so that both watermark directions cross their limit many times.

// File: rtl/afifo_pkg.sv
`timescale 1ns/1ps
package afifo_pkg;
    localparam int OP_FLUSH  = 0;
    localparam int OP_RUN    = 1;
    localparam int IRQ_W     = 16;
    localparam int IRQ_OFLOW = 2;
    localparam int IRQ_UFLOW = 3;
    localparam int IRQ_FULL  = 6;
    localparam int IRQ_EMPTY = 7;
    localparam int IRQ_RXWM  = 8;
    localparam int IRQ_TXWM  = 9;
endpackage

// File: rtl/afifo_store.sv
`timescale 1ns/1ps
module afifo_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    parameter int AW     = 5
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_word
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    assign rd_word = mem_q[rd_addr];
endmodule

// File: rtl/afifo_irq.sv
`timescale 1ns/1ps
module afifo_irq #(
    parameter int IRQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] set_mask,
    input  logic             clr_we,
    input  logic [IRQ_W-1:0] clr_mask,
    output logic [IRQ_W-1:0] status
);
    logic [IRQ_W-1:0] stat_d, stat_q;

    always_comb begin
        stat_d = stat_q;
        if (clr_we) stat_d = stat_d & ~clr_mask;
        stat_d = stat_d | set_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign status = stat_q;

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R10
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && set_mask == '0) |=> ((stat_q & $past(clr_mask)) == '0)); // R10
endmodule

// File: rtl/audio_wm_fifo.sv
`timescale 1ns/1ps
module audio_wm_fifo
    import afifo_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    parameter int LVL_W  = 7,
    parameter int IS_RX  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_we,
    input  logic [1:0]        op_wdata,
    input  logic              thr_we,
    input  logic [LVL_W-1:0]  thr_wdata,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic [LVL_W-1:0]  level,
    output logic              full,
    output logic              empty,
    output logic              req,
    input  logic              irq_clr_we,
    input  logic [IRQ_W-1:0]  irq_clr_data,
    output logic [IRQ_W-1:0]  irq_status
);
    localparam int AW      = $clog2(DEPTH);
    localparam int WM_BIT  = (IS_RX != 0) ? IRQ_RXWM : IRQ_TXWM;

    typedef struct packed {
        logic [AW-1:0]     wptr;
        logic [AW-1:0]     rptr;
        logic [LVL_W-1:0]  cnt;
        logic [1:0]        op;
        logic [LVL_W-1:0]  thr;
        logic [DATA_W-1:0] rdat;
    } st_t;

    st_t s_d, s_q;

    logic              run, is_full, is_empty, wm_hit;
    logic              do_push, do_pop, ufl, ofl;
    logic [DATA_W-1:0] head_word;
    logic [IRQ_W-1:0]  set_mask;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign run      = s_q.op[OP_RUN] && !s_q.op[OP_FLUSH];
    assign is_full  = (s_q.cnt == LVL_W'(DEPTH));
    assign is_empty = (s_q.cnt == '0);
    assign do_pop   = run && pop && !is_empty;
    assign ufl      = run && pop && is_empty;
    assign do_push  = run && push && (!is_full || do_pop);
    assign ofl      = run && push && is_full && !do_pop;

    generate
        if (IS_RX != 0) begin : g_rx_wm
            assign wm_hit = (s_q.cnt >= s_q.thr);
        end else begin : g_tx_wm
            assign wm_hit = (s_q.cnt <= s_q.thr);
        end
    endgenerate

    afifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk     (clk),
        .wr_en   (do_push),
        .wr_addr (s_q.wptr),
        .wr_data (push_data),
        .rd_addr (s_q.rptr),
        .rd_word (head_word)
    );

    always_comb begin
        s_d = s_q;
        if (do_push) s_d.wptr = ptr_inc(s_q.wptr);
        if (do_pop) begin
            s_d.rptr = ptr_inc(s_q.rptr);
            s_d.rdat = head_word;
        end else if (ufl) begin
            s_d.rdat = '0;
        end
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
        if (s_q.op[OP_FLUSH]) begin
            s_d.wptr = '0;
            s_d.rptr = '0;
            s_d.cnt  = '0;
        end
        if (op_we)  s_d.op  = op_wdata;
        if (thr_we) s_d.thr = thr_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.thr  <= LVL_W'(DEPTH / 2);
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        set_mask            = '0;
        set_mask[IRQ_OFLOW] = ofl;
        set_mask[IRQ_UFLOW] = ufl;
        set_mask[IRQ_FULL]  = run && is_full;
        set_mask[IRQ_EMPTY] = run && is_empty;
        set_mask[WM_BIT]    = run && wm_hit;
    end

    afifo_irq #(.IRQ_W(IRQ_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (set_mask),
        .clr_we   (irq_clr_we),
        .clr_mask (irq_clr_data),
        .status   (irq_status)
    );

    assign pop_data = s_q.rdat;
    assign level    = s_q.cnt;
    assign full     = is_full;
    assign empty    = is_empty;
    assign req      = run && wm_hit;

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH)); // R3
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty)); // R3
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.op[OP_FLUSH] |=> (level == '0)); // R1
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.op == 2'b00) |=> ($stable(level) && $stable(pop_data))); // R2
    AST_OFLOW_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && push && full && !pop) |=> (irq_status[IRQ_OFLOW] && level == LVL_W'(DEPTH))); // R4
    AST_UFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (run && pop && empty) |=> (pop_data == '0 && irq_status[IRQ_UFLOW])); // R5
    AST_FULL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (run && push && pop && full) |=> (level == LVL_W'(DEPTH))); // R11
    AST_REQ_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> irq_status[WM_BIT]); // R8
endmodule

// File: tb/tb_audio_wm_fifo.sv
`timescale 1ns/1ps
module tb_audio_wm_fifo;
    localparam int DW = 32;
    localparam int DEPTH = 32;
    localparam int LW = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          op_we = 0, thr_we = 0, push = 0, pop = 0, clr_we = 0;
    logic [1:0]    op_wdata = 0;
    logic [LW-1:0] thr_wdata = 0;
    logic [DW-1:0] push_data = 0;
    logic [15:0]   clr_data = 0;

    logic [DW-1:0] rx_pd, tx_pd;
    logic [LW-1:0] rx_lvl, tx_lvl;
    logic rx_full, rx_empty, rx_req, tx_full, tx_empty, tx_req;
    logic [15:0] rx_irq, tx_irq;

    audio_wm_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .LVL_W(LW), .IS_RX(1)) dut (
        .clk(clk), .rst_n(rst_n), .op_we(op_we), .op_wdata(op_wdata),
        .thr_we(thr_we), .thr_wdata(thr_wdata), .push(push), .push_data(push_data),
        .pop(pop), .pop_data(rx_pd), .level(rx_lvl), .full(rx_full), .empty(rx_empty),
        .req(rx_req), .irq_clr_we(clr_we), .irq_clr_data(clr_data), .irq_status(rx_irq));

    audio_wm_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .LVL_W(LW), .IS_RX(0)) dut_tx (
        .clk(clk), .rst_n(rst_n), .op_we(op_we), .op_wdata(op_wdata),
        .thr_we(thr_we), .thr_wdata(thr_wdata), .push(push), .push_data(push_data),
        .pop(pop), .pop_data(tx_pd), .level(tx_lvl), .full(tx_full), .empty(tx_empty),
        .req(tx_req), .irq_clr_we(clr_we), .irq_clr_data(clr_data), .irq_status(tx_irq));

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    bit cmp_en = 0;

    logic [DW-1:0] mq[$];
    logic [1:0]    m_op;
    logic [LW-1:0] m_thr;
    logic [DW-1:0] m_rd;
    logic [15:0]   m_rx, m_tx;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model, advanced on every rising edge
    always @(posedge clk) begin : model
        int cnt;
        bit run, fl, em, pok, uf, wok, ovf;
        logic [15:0] com, srx, stx, clr;
        if (!rst_n) begin
            mq.delete();
            m_op = 2'b00; m_thr = 7'd16; m_rd = '0; m_rx = '0; m_tx = '0;
        end else begin
            cnt = mq.size();
            run = (m_op == 2'b10);
            fl  = (cnt == DEPTH);
            em  = (cnt == 0);
            pok = run && pop && !em;
            uf  = run && pop && em;
            wok = run && push && (!fl || pok);
            ovf = run && push && fl && !pok;
            com = '0;
            com[2] = ovf; com[3] = uf; com[6] = run && fl; com[7] = run && em;
            srx = com; srx[8] = run && (cnt >= int'(m_thr));
            stx = com; stx[9] = run && (cnt <= int'(m_thr));
            clr = clr_we ? clr_data : 16'h0;
            m_rx = (m_rx & ~clr) | srx;
            m_tx = (m_tx & ~clr) | stx;
            if (pok) m_rd = mq.pop_front();
            else if (uf) m_rd = '0;
            if (wok) mq.push_back(push_data);
            if (m_op[0]) mq.delete();
            if (op_we) m_op = op_wdata;
            if (thr_we) m_thr = thr_wdata;
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin : compare
        int cnt;
        bit run;
        if (rst_n && cmp_en && !done) begin
            cnt = mq.size();
            run = (m_op == 2'b10);
            chk("R3 rx level", 32'(rx_lvl), 32'(cnt));
            chk("R3 tx level", 32'(tx_lvl), 32'(cnt));
            chk("R3 rx full/empty", {30'd0, rx_full, rx_empty}, {30'd0, cnt == DEPTH, cnt == 0});
            chk("R3 tx full/empty", {30'd0, tx_full, tx_empty}, {30'd0, cnt == DEPTH, cnt == 0});
            chk("R6 rx pop_data", rx_pd, m_rd);
            chk("R6 tx pop_data", tx_pd, m_rd);
            chk("R9 R10 rx irq_status", {16'd0, rx_irq}, {16'd0, m_rx});
            chk("R9 R10 tx irq_status", {16'd0, tx_irq}, {16'd0, m_tx});
            chk("R8 rx req", {31'd0, rx_req}, {31'd0, run && (cnt >= int'(m_thr))});
            chk("R8 tx req", {31'd0, tx_req}, {31'd0, run && (cnt <= int'(m_thr))});
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic op_write(input logic [1:0] v);
        op_we = 1; op_wdata = v; tick(); op_we = 0;
    endtask

    task automatic push_n(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            push = 1; push_data = 32'(base + i); tick();
        end
        push = 0;
    endtask

    task automatic pop_n(input int n);
        for (int i = 0; i < n; i++) begin
            pop = 1; tick();
        end
        pop = 0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            done = 1;
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        cmp_en = 1;
        // reset state (R3)
        chk("R3 reset level", 32'(rx_lvl), 32'd0);
        chk("R3 reset empty", {31'd0, rx_empty}, 32'd1);
        chk("R10 reset irq rx", {16'd0, rx_irq}, 32'd0);
        chk("R8 reset req tx", {31'd0, tx_req}, 32'd0);

        // enable sequence: flush, clear, run
        op_write(2'b01); op_write(2'b00); op_write(2'b10);

        push_n(15, 100);
        chk("R7 R8 rx req below default watermark", {31'd0, rx_req}, 32'd0);
        chk("R7 R8 tx req below default watermark", {31'd0, tx_req}, 32'd1);
        push_n(1, 115);
        chk("R7 R8 rx req at watermark", {31'd0, rx_req}, 32'd1);
        chk("R7 R8 tx req at watermark", {31'd0, tx_req}, 32'd1);
        push_n(1, 116);
        chk("R8 tx req above watermark", {31'd0, tx_req}, 32'd0);
        push_n(15, 117);
        chk("R3 full at depth", {31'd0, rx_full}, 32'd1);
        push_n(2, 900);
        chk("R4 overflow flag", {31'd0, rx_irq[2]}, 32'd1);
        chk("R4 level after dropped push", 32'(rx_lvl), 32'd32);

        push = 1; pop = 1; push_data = 32'd500; tick(); push = 0; pop = 0;
        chk("R11 level after paired push/pop", 32'(rx_lvl), 32'd32);
        chk("R6 oldest word", rx_pd, 32'd100);

        op_write(2'b00);
        push = 1; pop = 1; push_data = 32'd777;
        repeat (3) tick();
        push = 0; pop = 0;
        chk("R2 level held while stopped", 32'(rx_lvl), 32'd32);
        chk("R2 pop_data held while stopped", rx_pd, 32'd100);

        op_write(2'b10);
        pop_n(1);
        chk("R6 next word", rx_pd, 32'd101);
        pop_n(33);
        chk("R5 underflow data", rx_pd, 32'd0);
        chk("R5 underflow flag", {31'd0, rx_irq[3]}, 32'd1);

        op_write(2'b00);
        clr_we = 1; clr_data = 16'hFFFF; tick(); clr_we = 0;
        chk("R10 cleared rx", {16'd0, rx_irq}, 32'd0);
        chk("R10 cleared tx", {16'd0, tx_irq}, 32'd0);

        op_write(2'b10);
        pop = 1; clr_we = 1; clr_data = 16'hFFFF; tick(); pop = 0; clr_we = 0;
        chk("R10 event beats clear rx", {16'd0, rx_irq}, 32'h0088);
        chk("R10 event beats clear tx", {16'd0, tx_irq}, 32'h0288);

        push_n(5, 300);
        op_write(2'b11);
        tick();
        chk("R1 flush empties level", 32'(rx_lvl), 32'd0);
        chk("R1 flush empty flag", {31'd0, rx_empty}, 32'd1);
        push_n(2, 400);
        chk("R1 flush beats run", 32'(rx_lvl), 32'd0);
        op_write(2'b10);

        thr_we = 1; thr_wdata = 7'd5; tick(); thr_we = 0;
        push_n(5, 600);
        chk("R7 rx req at new watermark", {31'd0, rx_req}, 32'd1);
        chk("R7 tx req at new watermark", {31'd0, tx_req}, 32'd1);
        push_n(1, 605);
        chk("R7 tx req above new watermark", {31'd0, tx_req}, 32'd0);

        // random phase, model compared every cycle
        for (int i = 0; i < 3000; i++) begin
            bit heavy = ((i / 250) % 2) == 0;
            push = heavy ? ($urandom % 4 != 0) : ($urandom % 4 == 0);
            pop  = heavy ? ($urandom % 4 == 0) : ($urandom % 4 != 0);
            push_data = $urandom;
            clr_we = ($urandom % 16 == 0);
            clr_data = 16'($urandom);
            op_we = ($urandom % 200 == 0);
            op_wdata = ($urandom % 3 == 0) ? 2'($urandom) : 2'b10;
            thr_we = ($urandom % 150 == 0);
            thr_wdata = 7'($urandom % 40);
            tick();
        end
        push = 0; pop = 0; clr_we = 0; op_we = 0; thr_we = 0;
        tick();

        done = 1;
        summary();
        $finish;
    end
endmodule